// File: doc/BRIEF.md
# Keyboard and Display Interface

This block connects a processor bus to a byte-wide input device (a keyboard) and a byte-wide output device (a display). Software reaches four registers with ordinary loads and stores. The registers sit in a four-entry window of the memory address space, and an address decoder picks the entry from the low address bits. The four registers hold the received byte, the byte sent to the display, a read-only status word and an interrupt-enable control word.

Software can poll the two ready flags in the status word. It can also set the per-direction enables and let a single combined interrupt line signal when either side needs attention. On the device side, the keyboard presents a byte with a one-cycle valid pulse, and that byte is always taken. The display takes a byte through a valid/ready handshake.

A byte that arrives before software has read the previous one replaces it and sets a sticky overrun flag.

Top module: `kbd_disp_port`

## Requirements
- R1: After reset the input-ready flag, both enables and the overrun flag are 0, the output-ready flag is 1, `irq` is 0 and `disp_valid` is 0.
- R2: A cycle with `key_valid` high stores `key_data` in the input data register and sets the input-ready flag (status bit 0) from the next cycle on.
- R3: A read of offset 0 returns the held byte and clears the input-ready flag and the overrun flag. If a key byte arrives in the same cycle as the read, the read returns the old byte, the new byte is stored, the input-ready flag stays 1 and no overrun is raised.
- R4: A read of offset 2 returns the status word. Bit 0 is input-ready, bit 1 is output-ready, bit 2 is the keyboard request, bit 3 is the display request and bit 4 is overrun. All other bits read 0.
- R5: A write to offset 1 loads the output data register, clears the output-ready flag and raises `disp_valid` with that byte on `disp_data` from the next cycle. A read of offset 1 returns the last byte written.
- R6: While `disp_valid` is high and `disp_ready` is low, `disp_valid` and `disp_data` hold. A cycle with both high hands the byte over, and the output-ready flag returns to 1 in the next cycle unless a new write to offset 1 occurs in that same cycle.
- R7: Offset 3 is read/write, with bit 0 as the keyboard enable and bit 1 as the display enable. The keyboard request is input-ready AND keyboard enable, the display request is output-ready AND display enable, and `irq` is the OR of the two requests.
- R8: A key byte that arrives while input-ready is 1, and with no read of offset 0 in that cycle, sets the overrun flag (status bit 4) and replaces the held byte.
- R9: Accesses whose address lies outside the four-entry window at `BASE` change nothing, and reads outside the window return 0. Writes to offsets 0 and 2 have no effect.
- R10: Read data appears on `bus_rdata` in the cycle after the read request. In every cycle after which no read was accepted, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| key_valid | input | 1 | Keyboard byte present this cycle |
| key_data | input | DATA_W | Keyboard byte |
| disp_valid | output | 1 | A byte is waiting for the display |
| disp_data | output | DATA_W | Byte offered to the display |
| disp_ready | input | 1 | The display accepts the offered byte |
| irq | output | 1 | Combined interrupt request |

## Verification
Every register effect is due one edge after its cause. A key byte, a register write, a data read or a display handshake at one rising edge shows in the status word, `irq`, `disp_valid` and `disp_data` right after that edge. Read data for a request made at one edge is on `bus_rdata` after that same edge.

The bench drives inputs just after each rising edge. Its reference model advances at the next rising edge from those inputs, and all four outputs are compared at the following falling edge, so each result is checked in the exact cycle it is due. The stimulus includes cycles where two causes coincide, such as a read together with a key arrival, or a display handshake together with a new write. This pins down which effect wins.

// File: rtl/kdi_pkg.sv
package kdi_pkg;

    typedef enum logic [1:0] {
        REG_KEYIN  = 2'd0,
        REG_SHOWBY = 2'd1,
        REG_FLAGS  = 2'd2,
        REG_ENABLE = 2'd3
    } reg_sel_e;

    localparam int unsigned FLG_IN_RDY  = 0;
    localparam int unsigned FLG_OUT_RDY = 1;
    localparam int unsigned FLG_KEY_REQ = 2;
    localparam int unsigned FLG_DSP_REQ = 3;
    localparam int unsigned FLG_OVERRUN = 4;
    localparam int unsigned FLG_USED    = 5;

    localparam int unsigned EN_KEY = 0;
    localparam int unsigned EN_DSP = 1;

    typedef struct packed {
        logic key_en;
        logic dsp_en;
    } enables_t;

endpackage

// File: rtl/kdi_decode.sv
module kdi_decode
    import kdi_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_any,
    output logic              rd_keyin,
    output logic              wr_showby,
    output logic              wr_enable,
    output reg_sel_e          which
);
    localparam int unsigned OFS_W = 2;

    logic hit;

    always_comb begin
        hit       = sel && (addr[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
        which     = reg_sel_e'(addr[OFS_W-1:0]);
        rd_any    = hit && !wr;
        rd_keyin  = rd_any && (which == REG_KEYIN);
        wr_showby = hit && wr && (which == REG_SHOWBY);
        wr_enable = hit && wr && (which == REG_ENABLE);
    end
endmodule

// File: rtl/kdi_in_reg.sv
module kdi_in_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_data,
    input  logic              consume,
    output logic [DATA_W-1:0] held,
    output logic              full,
    output logic              overrun
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
    } in_st_t;

    in_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (consume) begin
            st_d.full = 1'b0;
            st_d.ovr  = 1'b0;
        end
        if (key_valid) begin
            if (st_q.full && !consume) begin
                st_d.ovr = 1'b1;
            end
            st_d.data = key_data;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held    = st_q.data;
    assign full    = st_q.full;
    assign overrun = st_q.ovr;
endmodule

// File: rtl/kdi_out_reg.sv
module kdi_out_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              disp_ready,
    output logic [DATA_W-1:0] data,
    output logic              empty,
    output logic              disp_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.empty && disp_ready) begin
            st_d.empty = 1'b1;
        end
        if (load) begin
            st_d.data  = wdata;
            st_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data  <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign data       = st_q.data;
    assign empty      = st_q.empty;
    assign disp_valid = !st_q.empty;
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
    import kdi_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_data,
    output logic              disp_valid,
    output logic [DATA_W-1:0] disp_data,
    input  logic              disp_ready,
    output logic              irq
);
    typedef struct packed {
        enables_t          en;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    logic              rd_any, rd_keyin, wr_showby, wr_enable;
    reg_sel_e          which;
    logic [DATA_W-1:0] in_held, out_held;
    logic              in_ready, ovr, out_empty;
    logic              key_req, dsp_req;
    logic [DATA_W-1:0] flags_word, enable_word;
    top_st_t           st_d, st_q;

    kdi_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .sel       (bus_sel),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .rd_any    (rd_any),
        .rd_keyin  (rd_keyin),
        .wr_showby (wr_showby),
        .wr_enable (wr_enable),
        .which     (which)
    );

    kdi_in_reg #(.DATA_W(DATA_W)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_data  (key_data),
        .consume   (rd_keyin),
        .held      (in_held),
        .full      (in_ready),
        .overrun   (ovr)
    );

    kdi_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_showby),
        .wdata      (bus_wdata),
        .disp_ready (disp_ready),
        .data       (out_held),
        .empty      (out_empty),
        .disp_valid (disp_valid)
    );

    always_comb begin
        key_req = in_ready && st_q.en.key_en;
        dsp_req = out_empty && st_q.en.dsp_en;

        flags_word              = '0;
        flags_word[FLG_IN_RDY]  = in_ready;
        flags_word[FLG_OUT_RDY] = out_empty;
        flags_word[FLG_KEY_REQ] = key_req;
        flags_word[FLG_DSP_REQ] = dsp_req;
        flags_word[FLG_OVERRUN] = ovr;

        enable_word         = '0;
        enable_word[EN_KEY] = st_q.en.key_en;
        enable_word[EN_DSP] = st_q.en.dsp_en;

        st_d = st_q;
        if (wr_enable) begin
            st_d.en.key_en = bus_wdata[EN_KEY];
            st_d.en.dsp_en = bus_wdata[EN_DSP];
        end
        st_d.rdata = '0;
        if (rd_any) begin
            case (which)
                REG_KEYIN:  st_d.rdata = in_held;
                REG_SHOWBY: st_d.rdata = out_held;
                REG_FLAGS:  st_d.rdata = flags_word;
                default:    st_d.rdata = enable_word;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign disp_data = out_held;
    assign irq       = key_req || dsp_req;
endmodule

// File: rtl/kdi_checks.sv
module kdi_checks #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              key_valid,
    input logic              in_ready,
    input logic              ovr,
    input logic              key_en,
    input logic              disp_valid,
    input logic [DATA_W-1:0] disp_data,
    input logic              disp_ready,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_KEYIN  = BASE;
    localparam logic [ADDR_W-1:0] A_SHOWBY = BASE + ADDR_W'(1);

    logic rd_in, wr_out;
    assign rd_in  = bus_sel && !bus_wr && (bus_addr == A_KEYIN);
    assign wr_out = bus_sel && bus_wr && (bus_addr == A_SHOWBY);

    p_key_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> in_ready);

    p_read_clears_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_in && !key_valid) |=> (!in_ready && !ovr));

    p_write_offers_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> (disp_valid && disp_data == $past(bus_wdata)));

    p_hold_until_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready && !wr_out) |=> (disp_valid && $stable(disp_data)));

    p_taken_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready && !wr_out) |=> !disp_valid);

    p_key_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_en) |=> irq);

    p_overrun_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && in_ready && !rd_in) |=> ovr);
endmodule

bind kbd_disp_port kdi_checks #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BASE   (BASE)
) u_kdi_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .key_valid  (key_valid),
    .in_ready   (in_ready),
    .ovr        (ovr),
    .key_en     (st_q.en.key_en),
    .disp_valid (disp_valid),
    .disp_data  (disp_data),
    .disp_ready (disp_ready),
    .irq        (irq)
);

// File: tb/tb_kbd_disp_port.sv
module tb_kbd_disp_port;
    localparam int CLK_P  = 10;
    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam logic [AW-1:0] BASE = 8'h40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, key_data = '0;
    logic          key_valid = 1'b0, disp_ready = 1'b0;
    logic [DW-1:0] bus_rdata, disp_data;
    logic          disp_valid, irq;

    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_in_data = 0, m_out_data = 0, m_rdata = 0;
    bit m_in_rdy = 0, m_ovr = 0, m_out_rdy = 1, m_ken = 0, m_den = 0;

    kbd_disp_port #(.ADDR_W(AW), .DATA_W(DW), .BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_valid(key_valid), .key_data(key_data), .disp_valid(disp_valid),
        .disp_data(disp_data), .disp_ready(disp_ready), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int flags_now();
        int f = 0;
        if (m_in_rdy) f += 1;
        if (m_out_rdy) f += 2;
        if (m_in_rdy && m_ken) f += 4;
        if (m_out_rdy && m_den) f += 8;
        if (m_ovr) f += 16;
        return f;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_in_data = 0; m_out_data = 0; m_rdata = 0;
            m_in_rdy = 0; m_ovr = 0; m_out_rdy = 1; m_ken = 0; m_den = 0;
        end else begin
            bit inwin, rd;
            int ofs, nr;
            inwin = bus_sel && (bus_addr >= BASE) && (bus_addr < BASE + 4);
            ofs   = int'(bus_addr) - int'(BASE);
            rd    = inwin && !bus_wr;
            nr = 0;
            if (rd) begin
                case (ofs)
                    0: nr = m_in_data;
                    1: nr = m_out_data;
                    2: nr = flags_now();
                    default: nr = (m_ken ? 1 : 0) + (m_den ? 2 : 0);
                endcase
            end
            if (!m_out_rdy && disp_ready) m_out_rdy = 1;
            if (inwin && bus_wr && ofs == 1) begin
                m_out_data = int'(bus_wdata); m_out_rdy = 0;
            end
            if (inwin && bus_wr && ofs == 3) begin
                m_ken = bus_wdata[0]; m_den = bus_wdata[1];
            end
            if (rd && ofs == 0) begin
                m_in_rdy = 0; m_ovr = 0;
            end
            if (key_valid) begin
                if (m_in_rdy) m_ovr = 1;
                m_in_data = int'(key_data); m_in_rdy = 1;
            end
            m_rdata = nr;
        end
    end

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("rdata (R10)", int'(bus_rdata), m_rdata);
            cmp("irq (R7)", int'(irq), (m_in_rdy && m_ken) || (m_out_rdy && m_den) ? 1 : 0);
            cmp("disp_valid (R6)", int'(disp_valid), m_out_rdy ? 0 : 1);
            if (!m_out_rdy) cmp("disp_data (R5)", int'(disp_data), m_out_data);
        end
    end

    task automatic step(bit s, bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                        bit kv, logic [DW-1:0] kd);
        @(posedge clk); #1;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        key_valid = kv; key_data = kd;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, 0, '0);
    endtask

    task automatic rd(int ofs);
        step(1, 0, BASE + AW'(ofs), '0, 0, '0);
    endtask

    task automatic wr(int ofs, logic [DW-1:0] d);
        step(1, 1, BASE + AW'(ofs), d, 0, '0);
    endtask

    task automatic key(logic [DW-1:0] d);
        step(0, 0, '0, '0, 1, d);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1";  idle(2); rd(2); idle(1);
        cur_req = "R2";  key(8'h41); rd(2);
        cur_req = "R3";  rd(0); rd(2); idle(1);
        cur_req = "R8";  key(8'h42); key(8'h43); rd(2); idle(1);
        cur_req = "R3";  rd(0); rd(2);
        cur_req = "R7";  wr(3, 8'hFF); rd(3); rd(2); idle(1);
        cur_req = "R5";  disp_ready = 1'b0; wr(1, 8'h55); rd(1); rd(2);
        cur_req = "R6";  idle(3); wr(1, 8'h66); idle(2);
        disp_ready = 1'b1; idle(1); disp_ready = 1'b0;
        cur_req = "R6";  wr(1, 8'h77); disp_ready = 1'b1; wr(1, 8'h78); idle(2);
        disp_ready = 1'b0;
        cur_req = "R7";  key(8'h31); rd(2);
        cur_req = "R3";  step(1, 0, BASE, '0, 1, 8'h32); rd(2); rd(0); rd(2);
        cur_req = "R9";  step(1, 1, BASE + 8'd7, 8'h00, 0, '0); rd(3);
        step(1, 0, BASE - 8'd2, '0, 0, '0); step(1, 0, BASE + 8'd4, '0, 0, '0);
        wr(0, 8'hAA); wr(2, 8'hFF); rd(0); rd(2);
        step(1, 1, BASE + 8'd5, 8'h99, 0, '0); rd(1);
        cur_req = "R4";  key(8'h10); key(8'h11); wr(3, 8'h01); rd(2);
        cur_req = "R7";  wr(3, 8'h00); rd(3); idle(2);
        cur_req = "R10"; idle(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule